// File: doc/BRIEF.md
# Watchdog Timer with Control and Status Register

This block is a free-running watchdog counter with one byte-wide control and status register on a simple read/write port. Software picks one of four timeout lengths with a select input and must restart the counter before it reaches the chosen terminal count. When the counter reaches the terminal count without a restart, the block sets an interrupt flag. If reset mode is enabled, it also issues a one-cycle system reset request and records that the watchdog caused the reset.

The interrupt flag can be set by software to force an interrupt. It can only be cleared by a write that the surrounding write-protection logic marks as permitted. The reset-cause flag is not cleared by the watchdog's own reset. Only software or the power-on reset input clear it. The interrupt controller, the processor and the unlock sequence for protected writes sit outside the block. The block only consumes a one-bit "protected write permitted" qualifier.

Top module: `wdt_ctrl`

## Requirements
- R1: The power-on reset `rst_n` is asynchronous and active low, and its release is synchronised internally. While it is asserted, every register bit is 0, the counter is 0, and `irq` and `sys_rst_req` are low. This includes the reset-cause flag.
- R2: The register is decoded at address `CTRL_ADDR` (default 0xD8). Its bit layout is: bit 0 restart, bit 1 reset enable, bit 2 reset-cause flag, bit 3 interrupt flag, bits 7:4 read as 0. A read with `bus_sel` high at any other address returns 0. A write to any other address changes nothing.
- R3: The counter advances once per clock. A timeout occurs on the edge where the count stands at or beyond T-1, with T = 2^(BASE_LOG2 + STEP_LOG2*tmo_sel). With the defaults, `tmo_sel` values 0, 1, 2 and 3 give 2^17, 2^20, 2^23 and 2^26 cycles. After a restart or a timeout the counter restarts from 0, so the next timeout follows exactly T edges later.
- R4: Writing 1 to bit 0 clears the counter on that write edge. Bit 0 reads back 1 for exactly one cycle and then clears by itself. A restart on the edge that would otherwise time out suppresses that timeout.
- R5: Every timeout sets the interrupt flag, whatever the reset enable. The output `irq` is high exactly when the interrupt flag and the `irq_en` input are both 1.
- R6: A timeout while the reset enable is 1 produces a `sys_rst_req` pulse exactly one cycle wide, in the cycle after that edge. On the same edge it sets the reset-cause flag and clears the reset enable and the counter. The interrupt flag stays set.
- R7: The reset-cause flag is set only by a watchdog reset. A write of 0 to bit 2 clears it, and a write of 1 to bit 2 has no effect. A watchdog reset on the same edge as a clearing write leaves it set.
- R8: Any write of 1 to bit 3 sets the interrupt flag. With `irq_en` high, this raises `irq`.
- R9: A write of 0 to bit 3 clears the interrupt flag only when `wr_prot_ok` is high during the write. Otherwise it is ignored. A timeout on the same edge wins over the clear.
- R10: Bit 1 (reset enable) takes the written value on every write. While it is 0, timeouts never produce `sys_rst_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, asynchronous, active low |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from `bus_sel` and `bus_addr` |
| wr_prot_ok | input | 1 | Current write is a permitted protected write |
| tmo_sel | input | SEL_W | Timeout length select |
| irq_en | input | 1 | External watchdog interrupt enable |
| irq | output | 1 | Interrupt request |
| sys_rst_req | output | 1 | One-cycle system reset request |

## Verification
The timeout length is measured for all four select codes. Each measurement starts from a combined restart-and-clear write and counts edges until `irq` rises, which separates an off-by-one in the terminal compare from a wrong exponent step. Periodic restarts shorter than the timeout show that restart suppresses timeouts. Timeouts are run with reset enable both off and on. This separates "interrupt flag set on every timeout" from "reset request only when enabled", and counting `sys_rst_req` high cycles across two timeout periods shows that the pulse is single and that the enable clears itself. Writes of 0 and 1 to the two flags, with and without the protection qualifier, tell apart the set-only, protected-clear and clear-only behaviours. A cycle-by-cycle reference model checks every output on every clock throughout.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  localparam int CTRL_W      = 4;
  localparam int BIT_RESTART = 0;
  localparam int BIT_RST_EN  = 1;
  localparam int BIT_CAUSE   = 2;
  localparam int BIT_IFLAG   = 3;

  // Packed so that the register image matches the bit positions above.
  typedef struct packed {
    logic iflag;
    logic cause;
    logic rst_en;
    logic restart;
  } wdt_ctrl_t;

endpackage

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int BASE_LOG2 = 17,
  parameter int STEP_LOG2 = 3,
  parameter int SEL_W     = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [SEL_W-1:0] tmo_sel,
  output logic             tmo
);

  localparam int NSEL = 1 << SEL_W;
  localparam int CW   = BASE_LOG2 + STEP_LOG2 * (NSEL - 1);

  logic [CW-1:0]   cnt_q;
  logic [CW-1:0]   cnt_d;
  logic [NSEL-1:0] at_end;

  // One terminal comparator per selectable length.
  for (genvar g = 0; g < NSEL; g++) begin : g_term
    localparam int L = BASE_LOG2 + STEP_LOG2 * g;
    localparam logic [CW:0] LAST = ({{CW{1'b0}}, 1'b1} << L) - 1'b1;
    assign at_end[g] = ({1'b0, cnt_q} >= LAST);
  end

  assign tmo = at_end[tmo_sel] & ~restart;

  always_comb begin
    cnt_d = cnt_q + 1'b1;
    if (restart || tmo) begin
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic [CTRL_W-1:0] wbits,
  input  logic              prot_ok,
  input  logic              tmo,
  output wdt_ctrl_t         ctrl_q,
  output logic              restart,
  output logic              rst_req_q
);

  wdt_ctrl_t ctrl_d;
  logic      fire;
  logic      rst_req_d;

  assign restart = wr_hit & wbits[BIT_RESTART];
  assign fire    = tmo & ctrl_q.rst_en;

  always_comb begin
    ctrl_d         = ctrl_q;
    ctrl_d.restart = restart;

    if (wr_hit) begin
      ctrl_d.rst_en = wbits[BIT_RST_EN];
    end
    if (wr_hit && !wbits[BIT_CAUSE]) begin
      ctrl_d.cause = 1'b0;
    end
    if (wr_hit && wbits[BIT_IFLAG]) begin
      ctrl_d.iflag = 1'b1;
    end else if (wr_hit && prot_ok) begin
      ctrl_d.iflag = 1'b0;
    end

    // Hardware events take priority over software in the same cycle.
    if (tmo) begin
      ctrl_d.iflag = 1'b1;
    end
    if (fire) begin
      ctrl_d.rst_en = 1'b0;
      ctrl_d.cause  = 1'b1;
    end
    rst_req_d = fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      rst_req_q <= 1'b0;
    end else begin
      ctrl_q    <= ctrl_d;
      rst_req_q <= rst_req_d;
    end
  end

endmodule

// File: rtl/wdt_rdmux.sv
module wdt_rdmux
  import wdt_pkg::*;
#(
  parameter int               ADDR_W    = 8,
  parameter int               DATA_W    = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'hD8
) (
  input  logic              sel,
  input  logic [ADDR_W-1:0] addr,
  input  wdt_ctrl_t         ctrl,
  output logic [DATA_W-1:0] rdata
);

  always_comb begin
    rdata = '0;
    if (sel && (addr == CTRL_ADDR)) begin
      rdata[CTRL_W-1:0] = ctrl;
    end
  end

endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
#(
  parameter int                ADDR_W    = 8,
  parameter int                DATA_W    = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'hD8,
  parameter int                BASE_LOG2 = 17,
  parameter int                STEP_LOG2 = 3,
  parameter int                SEL_W     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              wr_prot_ok,
  input  logic [SEL_W-1:0]  tmo_sel,
  input  logic              irq_en,
  output logic              irq,
  output logic              sys_rst_req
);

  logic      rst_meta_n;
  logic      rst_sync_n;
  logic      wr_hit;
  logic      restart;
  logic      tmo;
  wdt_ctrl_t ctrl_q;

  // Asserted asynchronously, released on the second clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  assign wr_hit = bus_sel & bus_we & (bus_addr == CTRL_ADDR);

  wdt_counter #(
    .BASE_LOG2(BASE_LOG2),
    .STEP_LOG2(STEP_LOG2),
    .SEL_W    (SEL_W)
  ) u_cnt (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .restart(restart),
    .tmo_sel(tmo_sel),
    .tmo    (tmo)
  );

  wdt_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_hit   (wr_hit),
    .wbits    (bus_wdata[CTRL_W-1:0]),
    .prot_ok  (wr_prot_ok),
    .tmo      (tmo),
    .ctrl_q   (ctrl_q),
    .restart  (restart),
    .rst_req_q(sys_rst_req)
  );

  wdt_rdmux #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .CTRL_ADDR(CTRL_ADDR)
  ) u_rd (
    .sel  (bus_sel),
    .addr (bus_addr),
    .ctrl (ctrl_q),
    .rdata(bus_rdata)
  );

  assign irq = ctrl_q.iflag & irq_en;

endmodule

// File: rtl/wdt_ctrl_chk.sv
module wdt_ctrl_chk
  import wdt_pkg::*;
#(
  parameter int                ADDR_W    = 8,
  parameter int                DATA_W    = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'hD8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              wr_prot_ok,
  input logic              tmo,
  input wdt_ctrl_t         ctrl_q,
  input logic              sys_rst_req
);

  logic wr_here;
  assign wr_here = bus_sel & bus_we & (bus_addr == CTRL_ADDR);

  // R6: the reset request never lasts two cycles
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |=> !sys_rst_req);

  // R6: a reset request comes with the cause recorded and the enable dropped
  a_r6_cause_with_req: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |-> (ctrl_q.cause && !ctrl_q.rst_en));

  // R4: the restart bit clears itself one cycle later
  a_r4_restart_selfclear: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q.restart |=> !ctrl_q.restart);

  // R5: a timeout always leaves the interrupt flag set
  a_r5_tmo_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    tmo |=> ctrl_q.iflag);

  // R9: an unprotected write cannot clear the interrupt flag
  a_r9_unprot_keeps_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.iflag && !(wr_here && wr_prot_ok)) |=> ctrl_q.iflag);

  // R7: the cause flag holds unless software writes 0 to it
  a_r7_cause_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.cause && !(wr_here && !bus_wdata[BIT_CAUSE])) |=> ctrl_q.cause);

  // R10: with reset enable low there is no request in the next cycle
  a_r10_no_req_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q.rst_en |=> !sys_rst_req);

endmodule

bind wdt_ctrl wdt_ctrl_chk #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .CTRL_ADDR(CTRL_ADDR)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .bus_sel    (bus_sel),
  .bus_we     (bus_we),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .wr_prot_ok (wr_prot_ok),
  .tmo        (tmo),
  .ctrl_q     (ctrl_q),
  .sys_rst_req(sys_rst_req)
);

// File: tb/tb_wdt_ctrl.sv
module tb_wdt_ctrl;

  localparam int         BASE = 4;
  localparam int         STEP = 3;
  localparam logic [7:0] RA   = 8'hD8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic       bus_sel = 1'b0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_addr = 8'h00;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       wr_prot_ok = 1'b0;
  logic [1:0] tmo_sel = 2'd3;
  logic       irq_en = 1'b0;
  logic       irq;
  logic       sys_rst_req;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  wdt_ctrl #(
    .ADDR_W(8), .DATA_W(8), .CTRL_ADDR(RA),
    .BASE_LOG2(BASE), .STEP_LOG2(STEP), .SEL_W(2)
  ) dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wr_prot_ok(wr_prot_ok), .tmo_sel(tmo_sel), .irq_en(irq_en),
    .irq(irq), .sys_rst_req(sys_rst_req)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  longint m_cnt = 0;
  int     m_rel = 0;
  bit     m_rwt, m_en, m_cause, m_flag, m_req;
  bit     cmp_on = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_rel = 0;
      {m_rwt, m_en, m_cause, m_flag, m_req} = '0;
      cmp_on = 1'b1;
    end else if (m_rel < 2) begin
      m_rel++;
    end else begin
      bit     w, rs, to, en_was;
      longint t;
      w      = bus_sel && bus_we && (bus_addr == RA);
      rs     = w && bus_wdata[0];
      t      = longint'(1) << (BASE + STEP * int'(tmo_sel));
      to     = !rs && (m_cnt >= t - 1);
      en_was = m_en;
      m_cnt  = (rs || to) ? 0 : m_cnt + 1;
      m_rwt  = rs;
      if (w) m_en = bus_wdata[1];
      if (w && !bus_wdata[2]) m_cause = 1'b0;
      if (w && bus_wdata[3]) m_flag = 1'b1;
      else if (w && wr_prot_ok) m_flag = 1'b0;
      if (to) m_flag = 1'b1;
      if (to && en_was) begin m_en = 1'b0; m_cause = 1'b1; end
      m_req = to && en_was;
    end
  end

  always @(posedge clk) begin
    #1;
    if (cmp_on) begin
      chk("R5 irq vs model", int'(irq), int'(m_flag && irq_en));
      chk("R6 sys_rst_req vs model", int'(sys_rst_req), int'(m_req));
      chk("R2 rdata vs model", int'(bus_rdata),
          (bus_sel && bus_addr == RA) ? int'({m_flag, m_cause, m_en, m_rwt}) : 0);
    end
  end

  // ---------------- bus helpers ----------------
  task automatic wr(input logic [7:0] a, input logic [7:0] d, input bit p);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d; wr_prot_ok = p;
    @(negedge clk);
    bus_sel = 0; bus_we = 0; wr_prot_ok = 0; bus_wdata = 8'h00;
  endtask

  task automatic rd(input logic [7:0] a, output int v);
    @(negedge clk);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    #1 v = int'(bus_rdata);
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic measure(input int sel, input int expect_len, input string tag);
    int n;
    tmo_sel = 2'(sel);
    irq_en  = 1'b1;
    wr(RA, 8'h01, 1'b1);
    n = 0;
    while (!irq && n < 20000) begin
      @(negedge clk);
      n++;
    end
    chk(tag, n, expect_len);
  endtask

  task automatic count_req(input int cycles, output int hi);
    hi = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (sys_rst_req) hi++;
    end
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  // ---------------- directed sequence ----------------
  initial begin
    int v;
    int hi;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 irq in reset", int'(irq), 0);
    chk("R1 sys_rst_req in reset", int'(sys_rst_req), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    rd(RA, v);            chk("R1 register after reset", v, 0);

    // R2: other address neither writes nor reads
    wr(8'h10, 8'h0A, 1'b1);
    rd(RA, v);            chk("R2 foreign write ignored", v, 0);
    wr(8'h10, 8'h08, 1'b1);
    @(negedge clk); bus_sel = 1; bus_addr = 8'h10; #1;
    chk("R2 foreign read is zero", int'(bus_rdata), 0);
    @(negedge clk); bus_sel = 0;

    // R4: restart bit visible one cycle then gone
    wr(RA, 8'h01, 1'b0);
    bus_sel = 1; bus_addr = RA; #1;
    chk("R4 restart bit reads 1", int'(bus_rdata[0]), 1);
    @(negedge clk); #1;
    chk("R4 restart bit self-clears", int'(bus_rdata[0]), 0);
    bus_sel = 0;

    // R3: timeout length for each select code
    measure(1, 128,  "R3 length sel=1");
    measure(0, 16,   "R3 length sel=0");
    measure(2, 1024, "R3 length sel=2");
    measure(3, 8192, "R3 length sel=3");

    // R5: output gating by irq_en
    irq_en = 1'b0; #1;
    chk("R5 irq masked", int'(irq), 0);
    irq_en = 1'b1; #1;
    chk("R5 irq unmasked", int'(irq), 1);

    // R9: unprotected clear ignored, protected clear accepted
    wr(RA, 8'h01, 1'b0);
    rd(RA, v);            chk("R9 unprotected clear ignored", (v >> 3) & 1, 1);
    wr(RA, 8'h01, 1'b1);
    rd(RA, v);            chk("R9 protected clear", (v >> 3) & 1, 0);
    chk("R9 irq low after clear", int'(irq), 0);

    // R8: software set forces interrupt
    wr(RA, 8'h08, 1'b0);
    #1 chk("R8 software set raises irq", int'(irq), 1);
    wr(RA, 8'h01, 1'b1);

    // R4: restarts every 10 cycles keep a 16-cycle watchdog quiet
    tmo_sel = 2'd0;
    wr(RA, 8'h01, 1'b1);
    for (int i = 0; i < 10; i++) begin
      repeat (8) @(negedge clk);
      wr(RA, 8'h01, 1'b0);
    end
    rd(RA, v);            chk("R4 restarts prevent timeout", (v >> 3) & 1, 0);

    // R10: reset enable off, timeout gives flag but no request
    wr(RA, 8'h01, 1'b1);
    count_req(40, hi);    chk("R10 no request when disabled", hi, 0);
    rd(RA, v);            chk("R5 flag set with reset disabled", (v >> 3) & 1, 1);

    // R6: reset enable on, one single-cycle request
    wr(RA, 8'h03, 1'b1);
    count_req(40, hi);    chk("R6 exactly one request cycle", hi, 1);
    rd(RA, v);            chk("R6 cause set, enable cleared, flag kept", v, 8'h0C);

    // R7: cause flag write rules
    tmo_sel = 2'd3;
    wr(RA, 8'h05, 1'b0);
    rd(RA, v);            chk("R7 write 1 keeps cause", (v >> 2) & 1, 1);
    wr(RA, 8'h01, 1'b0);
    rd(RA, v);            chk("R7 write 0 clears cause", v, 8'h08);

    // R10: enable bit follows writes
    wr(RA, 8'h02, 1'b0);
    rd(RA, v);            chk("R10 enable written", (v >> 1) & 1, 1);
    wr(RA, 8'h08, 1'b0);
    rd(RA, v);            chk("R10 enable cleared by write", (v >> 1) & 1, 0);

    // R1: power-on reset clears cause flag too
    tmo_sel = 2'd0;
    wr(RA, 8'h03, 1'b1);
    repeat (20) @(negedge clk);
    rd(RA, v);            chk("R6 cause before power-on reset", (v >> 2) & 1, 1);
    rst_n = 1'b0;
    @(negedge clk); bus_sel = 1; bus_addr = RA; #1;
    chk("R1 power-on reset clears all", int'(bus_rdata), 0);
    bus_sel = 0;
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule